// File: doc/BRIEF.md
# Paired Transmit/Receive FIFO with DMA Request Thresholds

This block sits between a register or DMA side and a serial shifting engine. It holds two 8-entry queues: the transmit queue is filled from the DMA side and drained by the serial engine, and the receive queue is filled by the serial engine and drained from the DMA side. Each queue has an occupancy count, a self-clearing flush command, a DMA enable and a 3-bit threshold code. Each queue raises a DMA request when that code's level is reached.

The two requests measure different things. The transmit request looks at free slots, so the DMA refills the queue before it runs dry. The receive request looks at filled slots, so the DMA empties the queue before it overflows. In both directions a code of n stands for n+1 entries. Pushes into a full queue are discarded and reported as an overrun. Pops from an empty queue return zero and are reported as an underrun. Configuration is written and read back as one word.

Top module: `xfer_fifo_pair`

## Requirements
- R1: After reset both counts are 0, every request, overrun and underrun output is low, and `cfg_rdata` reads 0x0E7 (both threshold codes 7, flush and enable bits 0).
- R2: Each queue keeps first-in-first-out order for up to 8 entries. Its count rises or falls by one on the clock edge that accepts a push or a pop. The head entry is visible on its read-data output while the queue is not empty.
- R3: A push into a full queue with no pop in the same cycle is discarded. The count stays 8, and the overrun output is high for exactly the one cycle after that edge.
- R4: While a queue is empty its read-data output is zero. A pop of an empty queue leaves the count at 0 and raises the underrun output for exactly the one cycle after that edge.
- R5: `tx_dma_req` is high exactly when the transmit enable (`cfg` bit 4) is 1 and the free slots (8 - `tx_count`) are at least the transmit code (`cfg` bits [2:0]) plus one.
- R6: `rx_dma_req` is high exactly when the receive enable (`cfg` bit 9) is 1 and `rx_count` is at least the receive code (`cfg` bits [7:5]) plus one.
- R7: While a direction's enable bit is 0, its request output stays low whatever the occupancy.
- R8: Writing 1 to a flush bit (transmit bit 3, receive bit 8) makes that bit read 1 for one cycle. On the following edge the queue empties, its count becomes 0, the bit reads 0 again, and a push presented during that cycle is discarded.
- R9: A push and a pop in the same cycle on a full queue are both accepted. The count stays 8 and no overrun is reported.
- R10: A configuration write is stored on the clock edge at which `cfg_we` is high and reads back on `cfg_rdata` from then on. The request outputs follow the new fields from that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration word to store |
| cfg_rdata | output | 10 | Stored configuration word |
| tx_push | input | 1 | Transmit queue push (DMA side) |
| tx_wdata | input | 16 | Transmit push data |
| tx_pop | input | 1 | Transmit queue pop (serial side) |
| tx_rdata | output | 16 | Transmit head entry, zero when empty |
| tx_count | output | 4 | Transmit queue occupancy |
| tx_overrun | output | 1 | One-cycle pulse: transmit push discarded |
| tx_underrun | output | 1 | One-cycle pulse: transmit pop while empty |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_push | input | 1 | Receive queue push (serial side) |
| rx_wdata | input | 16 | Receive push data |
| rx_pop | input | 1 | Receive queue pop (DMA side) |
| rx_rdata | output | 16 | Receive head entry, zero when empty |
| rx_count | output | 4 | Receive queue occupancy |
| rx_overrun | output | 1 | One-cycle pulse: receive push discarded |
| rx_underrun | output | 1 | One-cycle pulse: receive pop while empty |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that no pop is presented while a flush is in progress. They also assume that a flush bit is not written again in the cycle in which it clears itself. The overrun, underrun and flush properties leave those cycles out of their antecedents. The stimulus keeps within these assumptions: every flush is a single write, followed by one cycle in which only a push is offered to the queue being flushed. The threshold boundaries are probed by stepping occupancy one entry at a time across the level that each code selects.

// File: rtl/xfp_pkg.sv
`timescale 1ns/1ps
package xfp_pkg;

    // What a request generator measures against its threshold.
    typedef enum logic {
        REQ_ON_FREE   = 1'b0,
        REQ_ON_FILLED = 1'b1
    } req_mode_e;

    // Channel slots inside the configuration word.
    localparam int CH_TX  = 0;
    localparam int CH_RX  = 1;
    localparam int N_CHAN = 2;

endpackage

// File: rtl/xfp_fifo_core.sv
`timescale 1ns/1ps
module xfp_fifo_core #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              overrun,
    output logic              underrun
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             ovr;
        logic             unr;
    } state_t;

    state_t state_d, state_q;

    logic [DATA_W-1:0] mem_q [DEPTH];

    logic full, empty, do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        full    = (state_q.cnt == CNT_W'(DEPTH));
        empty   = (state_q.cnt == '0);
        do_pop  = pop && !empty && !flush;
        do_push = push && (!full || do_pop) && !flush;

        state_d = state_q;
        if (flush) begin
            state_d.wptr = '0;
            state_d.rptr = '0;
            state_d.cnt  = '0;
            state_d.ovr  = 1'b0;
            state_d.unr  = 1'b0;
        end else begin
            if (do_push) begin
                state_d.wptr = bump(state_q.wptr);
            end
            if (do_pop) begin
                state_d.rptr = bump(state_q.rptr);
            end
            case ({do_push, do_pop})
                2'b10:   state_d.cnt = state_q.cnt + 1'b1;
                2'b01:   state_d.cnt = state_q.cnt - 1'b1;
                default: state_d.cnt = state_q.cnt;
            endcase
            state_d.ovr = push && !do_push;
            state_d.unr = pop && empty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[state_q.wptr] <= wdata;
        end
    end

    assign rdata    = empty ? '0 : mem_q[state_q.rptr];
    assign count    = state_q.cnt;
    assign overrun  = state_q.ovr;
    assign underrun = state_q.unr;

endmodule

// File: rtl/xfp_req_gen.sv
`timescale 1ns/1ps
module xfp_req_gen
    import xfp_pkg::*;
#(
    parameter int        DEPTH = 8,
    parameter int        CNT_W = 4,
    parameter int        THR_W = 3,
    parameter req_mode_e MODE  = REQ_ON_FILLED
) (
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thr,
    input  logic             enable,
    output logic             req
);

    localparam int LVL_W = CNT_W + 1;

    logic [LVL_W-1:0] level;

    generate
        if (MODE == REQ_ON_FREE) begin : g_free
            always_comb level = LVL_W'(DEPTH) - {1'b0, count};
        end else begin : g_filled
            always_comb level = {1'b0, count};
        end
    endgenerate

    // A code of n means n+1 entries, i.e. level strictly above the code.
    assign req = enable && (level > LVL_W'(thr));

endmodule

// File: rtl/xfp_cfg_regs.sv
`timescale 1ns/1ps
module xfp_cfg_regs
    import xfp_pkg::*;
#(
    parameter int THR_W = 3,
    parameter int CFG_W = 2 * THR_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg
);

    localparam int SLOT_W = THR_W + 2;
    localparam logic [SLOT_W-1:0] SLOT_RST = {2'b00, {THR_W{1'b1}}};
    localparam logic [CFG_W-1:0]  CFG_RST  = {N_CHAN{SLOT_RST}};

    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        // Flush bits clear themselves one edge after being set.
        for (int ch = 0; ch < N_CHAN; ch++) begin
            cfg_d[ch * SLOT_W + THR_W] = 1'b0;
        end
        if (we) begin
            cfg_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/xfer_fifo_pair.sv
`timescale 1ns/1ps
module xfer_fifo_pair
    import xfp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int THR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CFG_W = 2 * THR_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_overrun,
    output logic              tx_underrun,
    output logic              tx_dma_req,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_overrun,
    output logic              rx_underrun,
    output logic              rx_dma_req
);

    localparam int SLOT_W = THR_W + 2;

    logic [CFG_W-1:0] cfg_q;

    logic [N_CHAN-1:0] ch_push, ch_pop, ch_ovr, ch_unr, ch_req;
    logic [DATA_W-1:0] ch_wdata [N_CHAN];
    logic [DATA_W-1:0] ch_rdata [N_CHAN];
    logic [CNT_W-1:0]  ch_cnt   [N_CHAN];

    xfp_cfg_regs #(
        .THR_W (THR_W),
        .CFG_W (CFG_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    assign ch_push = {rx_push, tx_push};
    assign ch_pop  = {rx_pop, tx_pop};
    assign ch_wdata[CH_TX] = tx_wdata;
    assign ch_wdata[CH_RX] = rx_wdata;

    generate
        for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
            localparam int        BASE = g * SLOT_W;
            localparam req_mode_e MODE = (g == CH_TX) ? REQ_ON_FREE : REQ_ON_FILLED;

            xfp_fifo_core #(
                .DATA_W (DATA_W),
                .DEPTH  (DEPTH),
                .CNT_W  (CNT_W)
            ) u_fifo (
                .clk      (clk),
                .rst_n    (rst_n),
                .flush    (cfg_q[BASE + THR_W]),
                .push     (ch_push[g]),
                .wdata    (ch_wdata[g]),
                .pop      (ch_pop[g]),
                .rdata    (ch_rdata[g]),
                .count    (ch_cnt[g]),
                .overrun  (ch_ovr[g]),
                .underrun (ch_unr[g])
            );

            xfp_req_gen #(
                .DEPTH (DEPTH),
                .CNT_W (CNT_W),
                .THR_W (THR_W),
                .MODE  (MODE)
            ) u_req (
                .count  (ch_cnt[g]),
                .thr    (cfg_q[BASE +: THR_W]),
                .enable (cfg_q[BASE + THR_W + 1]),
                .req    (ch_req[g])
            );
        end
    endgenerate

    assign cfg_rdata   = cfg_q;
    assign tx_rdata    = ch_rdata[CH_TX];
    assign tx_count    = ch_cnt[CH_TX];
    assign tx_overrun  = ch_ovr[CH_TX];
    assign tx_underrun = ch_unr[CH_TX];
    assign tx_dma_req  = ch_req[CH_TX];
    assign rx_rdata    = ch_rdata[CH_RX];
    assign rx_count    = ch_cnt[CH_RX];
    assign rx_overrun  = ch_ovr[CH_RX];
    assign rx_underrun = ch_unr[CH_RX];
    assign rx_dma_req  = ch_req[CH_RX];

endmodule

// File: rtl/xfp_chk.sv
`timescale 1ns/1ps
module xfp_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int THR_W  = 3,
    parameter int CNT_W  = 4,
    parameter int CFG_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic              tx_push,
    input logic              tx_pop,
    input logic [DATA_W-1:0] tx_rdata,
    input logic [CNT_W-1:0]  tx_count,
    input logic              tx_overrun,
    input logic              tx_underrun,
    input logic              tx_dma_req,
    input logic [CNT_W-1:0]  rx_count,
    input logic              rx_dma_req
);

    localparam int RX_BASE = THR_W + 2;

    logic [THR_W-1:0] tx_thr, rx_thr;
    logic             tx_flush, tx_en, rx_en;

    assign tx_thr   = cfg_rdata[THR_W-1:0];
    assign tx_flush = cfg_rdata[THR_W];
    assign tx_en    = cfg_rdata[THR_W + 1];
    assign rx_thr   = cfg_rdata[RX_BASE +: THR_W];
    assign rx_en    = cfg_rdata[RX_BASE + THR_W + 1];

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_count) <= DEPTH) && (int'(rx_count) <= DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_count) == DEPTH && tx_push && !tx_pop && !tx_flush)
        |=> (int'(tx_count) == DEPTH && tx_overrun));

    p_underrun_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0 && tx_pop && !tx_flush) |=> (tx_underrun && tx_count == '0));

    p_empty_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> (tx_rdata == '0));

    p_tx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> ((DEPTH - int'(tx_count)) > int'(tx_thr)));

    p_rx_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (int'(rx_count) > int'(rx_thr)));

    p_req_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en |-> !tx_dma_req) and (!rx_en |-> !rx_dma_req));

    p_flush_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !cfg_we) |=> (tx_count == '0 && !tx_flush));

    p_full_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_count) == DEPTH && tx_push && tx_pop && !tx_flush)
        |=> (int'(tx_count) == DEPTH && !tx_overrun));

endmodule

bind xfer_fifo_pair xfp_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .THR_W  (THR_W),
    .CNT_W  (CNT_W),
    .CFG_W  (CFG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_rdata   (cfg_rdata),
    .tx_push     (tx_push),
    .tx_pop      (tx_pop),
    .tx_rdata    (tx_rdata),
    .tx_count    (tx_count),
    .tx_overrun  (tx_overrun),
    .tx_underrun (tx_underrun),
    .tx_dma_req  (tx_dma_req),
    .rx_count    (rx_count),
    .rx_dma_req  (rx_dma_req)
);

// File: tb/tb_xfer_fifo_pair.sv
`timescale 1ns/1ps
module tb_xfer_fifo_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_wdata = '0;
    logic [9:0]  cfg_rdata;
    logic        tx_push = 1'b0, tx_pop = 1'b0;
    logic [15:0] tx_wdata = '0, tx_rdata;
    logic [3:0]  tx_count;
    logic        tx_overrun, tx_underrun, tx_dma_req;
    logic        rx_push = 1'b0, rx_pop = 1'b0;
    logic [15:0] rx_wdata = '0, rx_rdata;
    logic [3:0]  rx_count;
    logic        rx_overrun, rx_underrun, rx_dma_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    xfer_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_count(tx_count), .tx_overrun(tx_overrun), .tx_underrun(tx_underrun), .tx_dma_req(tx_dma_req),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_count(rx_count), .rx_overrun(rx_overrun), .rx_underrun(rx_underrun), .rx_dma_req(rx_dma_req)
    );

    typedef struct packed {
        logic        push;
        logic        pop;
        logic [15:0] wdata;
        logic [15:0] head;
        logic [3:0]  cnt;
        logic        req;
        logic        ovr;
    } vec_t;

    // Transmit queue walk with code 3 (request while at least 4 slots free).
    localparam vec_t VEC [14] = '{
        '{1'b1, 1'b0, 16'hA001, 16'h0000, 4'd1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 16'hA002, 16'h0000, 4'd2, 1'b1, 1'b0},
        '{1'b1, 1'b0, 16'hA003, 16'h0000, 4'd3, 1'b1, 1'b0},
        '{1'b1, 1'b0, 16'hA004, 16'h0000, 4'd4, 1'b1, 1'b0},
        '{1'b1, 1'b0, 16'hA005, 16'h0000, 4'd5, 1'b0, 1'b0},
        '{1'b1, 1'b1, 16'hA006, 16'hA001, 4'd5, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'hA007, 16'h0000, 4'd6, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'hA008, 16'h0000, 4'd7, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'hA009, 16'h0000, 4'd8, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'hBEEF, 16'h0000, 4'd8, 1'b0, 1'b1},
        '{1'b0, 1'b1, 16'h0000, 16'hA002, 4'd7, 1'b0, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 16'hA003, 4'd6, 1'b0, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 16'hA004, 4'd5, 1'b0, 1'b0},
        '{1'b0, 1'b1, 16'h0000, 16'hA005, 4'd4, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [9:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic tx_op(input logic push, input logic pop, input logic [15:0] d);
        tx_push = push;
        tx_pop = pop;
        tx_wdata = d;
        @(negedge clk);
        tx_push = 1'b0;
        tx_pop = 1'b0;
    endtask

    task automatic rx_op(input logic push, input logic pop, input logic [15:0] d);
        rx_push = push;
        rx_pop = pop;
        rx_wdata = d;
        @(negedge clk);
        rx_push = 1'b0;
        rx_pop = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 cfg", 32'(cfg_rdata), 32'h0E7);
        chk("R1 counts", {tx_count, rx_count}, 8'h00);
        chk("R1 flags", {tx_dma_req, rx_dma_req, tx_overrun, rx_overrun, tx_underrun, rx_underrun}, 6'b0);

        // R10: tx code 3, tx enable on, rx code 7, rx enable off
        cfg_write(10'h0F3);
        chk("R10 readback", 32'(cfg_rdata), 32'h0F3);
        chk("R5 req empty tx", 32'(tx_dma_req), 32'd1);

        // R2/R3/R5/R9: table walk on transmit queue
        for (int i = 0; i < 14; i++) begin
            if (VEC[i].pop) chk("R2 head", 32'(tx_rdata), 32'(VEC[i].head));
            tx_op(VEC[i].push, VEC[i].pop, VEC[i].wdata);
            chk("R2 count", 32'(tx_count), 32'(VEC[i].cnt));
            chk("R5 tx req", 32'(tx_dma_req), 32'(VEC[i].req));
            chk("R3 overrun", 32'(tx_overrun), 32'(VEC[i].ovr));
        end

        // R9: fill to 8, then push and pop together
        for (int i = 1; i <= 4; i++) tx_op(1'b1, 1'b0, 16'(16'hC000 + i));
        chk("R2 refill", 32'(tx_count), 32'd8);
        chk("R9 head", 32'(tx_rdata), 32'hA006);
        tx_op(1'b1, 1'b1, 16'hC005);
        chk("R9 count", 32'(tx_count), 32'd8);
        chk("R9 no overrun", 32'(tx_overrun), 32'd0);

        // R3: lone push while full
        tx_op(1'b1, 1'b0, 16'hDEAD);
        chk("R3 count", 32'(tx_count), 32'd8);
        chk("R3 pulse", 32'(tx_overrun), 32'd1);
        @(negedge clk);
        chk("R3 pulse end", 32'(tx_overrun), 32'd0);
        begin
            logic [15:0] exp_q [8];
            exp_q = '{16'hA007, 16'hA008, 16'hA009, 16'hC001, 16'hC002, 16'hC003, 16'hC004, 16'hC005};
            for (int i = 0; i < 8; i++) begin
                chk("R3 order", 32'(tx_rdata), 32'(exp_q[i]));
                tx_op(1'b0, 1'b1, 16'h0);
            end
        end
        chk("R2 drained", 32'(tx_count), 32'd0);

        // R4: pop while empty
        chk("R4 zero data", 32'(tx_rdata), 32'd0);
        tx_op(1'b0, 1'b1, 16'h0);
        chk("R4 count", 32'(tx_count), 32'd0);
        chk("R4 pulse", 32'(tx_underrun), 32'd1);
        @(negedge clk);
        chk("R4 pulse end", 32'(tx_underrun), 32'd0);

        // R8: flush with a push offered during the flush cycle
        for (int i = 1; i <= 3; i++) tx_op(1'b1, 1'b0, 16'(16'hE000 + i));
        cfg_write(10'h0FB);
        chk("R8 bit set", 32'(cfg_rdata[3]), 32'd1);
        chk("R8 count held", 32'(tx_count), 32'd3);
        tx_op(1'b1, 1'b0, 16'hE004);
        chk("R8 count cleared", 32'(tx_count), 32'd0);
        chk("R8 bit cleared", 32'(cfg_rdata), 32'h0F3);
        chk("R8 data zero", 32'(tx_rdata), 32'd0);

        // R7: disable forces request low even when empty
        chk("R5 before disable", 32'(tx_dma_req), 32'd1);
        cfg_write(10'h0E3);
        chk("R7 tx gated", 32'(tx_dma_req), 32'd0);

        // R6: rx code 2, enable on
        cfg_write(10'h243);
        rx_op(1'b1, 1'b0, 16'h0011);
        chk("R6 one", 32'(rx_dma_req), 32'd0);
        rx_op(1'b1, 1'b0, 16'h0022);
        chk("R6 two", 32'(rx_dma_req), 32'd0);
        rx_op(1'b1, 1'b0, 16'h0033);
        chk("R6 three", 32'(rx_dma_req), 32'd1);
        chk("R2 rx head", 32'(rx_rdata), 32'h0011);
        rx_op(1'b0, 1'b1, 16'h0);
        chk("R6 after pop", 32'(rx_dma_req), 32'd0);

        // R6 at code 7: request only when full
        cfg_write(10'h2E3);
        for (int i = 0; i < 5; i++) rx_op(1'b1, 1'b0, 16'(i));
        chk("R6 seven", {28'h0, rx_count}, 32'd7);
        chk("R6 code7 at 7", 32'(rx_dma_req), 32'd0);
        rx_op(1'b1, 1'b0, 16'h0077);
        chk("R6 code7 at 8", 32'(rx_dma_req), 32'd1);
        chk("R7 tx still off", 32'(tx_dma_req), 32'd0);

        // R5 at code 0: request while at least one slot free
        cfg_write(10'h2F0);
        for (int i = 0; i < 7; i++) tx_op(1'b1, 1'b0, 16'(i));
        chk("R5 code0 at 7", 32'(tx_dma_req), 32'd1);
        tx_op(1'b1, 1'b0, 16'h0099);
        chk("R5 code0 at 8", 32'(tx_dma_req), 32'd0);

        // R1: reset in mid-run
        rst_n = 1'b0;
        #1;
        chk("R1 mid counts", {tx_count, rx_count}, 8'h00);
        chk("R1 mid cfg", 32'(cfg_rdata), 32'h0E7);
        chk("R1 mid req", {tx_dma_req, rx_dma_req}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule